// File: doc/BRIEF.md
# Arbiter Handshake Monitor

This block watches the request, grant and acknowledge vectors of an N-port arbiter and reports misbehaviour. It drives nothing back into the arbiter. It checks four things:

- no two ports are granted in the same cycle;
- no grant goes to a port that is not asking;
- no request waits beyond a configurable number of cycles;
- every port follows the handshake: request held until a single-cycle grant, ownership, then a single-cycle acknowledge.

Each port is followed by a small tracker with three states: idle, waiting and holding. A grant moves a port to holding and an acknowledge returns it to idle. Violations are grouped into four classes. Each class has its own sticky flag. A one-cycle pulse also reports the cause code and the port index of the most important violation seen in that cycle. All outputs are registered, so a violation on the inputs in cycle t shows on the outputs after the clock edge that ends cycle t.

Top module: `arb_proto_monitor`

## Requirements
- R1: When more than one `gnt` bit is high in a cycle, sticky bit 0 (mutual exclusion) is set.
- R2: When `gnt[i]` is high while `req[i]` is low, sticky bit 1 (wasted grant) is set.
- R3: A request that stays high without a grant, while its port is not holding, is flagged on its (STARVE_LIMIT+1)-th waiting cycle by sticky bit 2. The flag fires once. The wait count saturates and clears only on that port's grant or on reset.
- R4: A port in the waiting state whose `req` falls with no grant in the same cycle raises a protocol error (sticky bit 3).
- R5: A grant or an acknowledge that is high on the same port for two consecutive cycles raises a protocol error.
- R6: An acknowledge on a port that is not in the holding state raises a protocol error.
- R7: A grant on any port while any port is holding raises a protocol error.
- R8: Sticky bits never clear except by reset.
- R9: `err_pulse` is high for one cycle after a cycle with any violation. The cause codes are 0 none, 1 mutex, 2 waste, 3 starvation and 4 protocol. When several classes occur in one cycle, the lowest non-zero code wins. `err_port` is the lowest-index port of that class, and 0 when there is no violation.
- R10: Synchronous active-high reset clears the sticky bits, pulse, code, port, all port states and all wait counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_PORTS | Request per port |
| gnt | input | N_PORTS | Grant per port |
| ack | input | N_PORTS | Release acknowledge per port |
| err_sticky | output | 4 | Sticky flags: bit0 mutex, bit1 waste, bit2 starvation, bit3 protocol |
| err_pulse | output | 1 | One-cycle indication of a violation |
| err_code | output | 3 | Cause code of the reported violation |
| err_port | output | $clog2(N_PORTS) | Port index of the reported violation |

## Verification
The properties assume that `req`, `gnt` and `ack` are free of X and change only between clock edges. They also assume that all three vectors are low while reset is held. The internal one-cycle history of grant and acknowledge is not reset, so the checks on "two cycles in a row" rely on quiet inputs during reset. The stimulus meets these assumptions: it holds every input at zero through each reset, and it changes inputs only on falling clock edges. This applies to both the directed handshake sequences and the random stretch, which drives arbitrary vectors.

// File: rtl/arbmon_pkg.sv
package arbmon_pkg;
  localparam int NUM_CLASSES = 4;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_HOLD = 2'd2
  } port_state_t;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_MUTEX  = 3'd1,
    CAUSE_WASTE  = 3'd2,
    CAUSE_STARVE = 3'd3,
    CAUSE_PROTO  = 3'd4
  } cause_t;
endpackage

// File: rtl/arbmon_port_track.sv
module arbmon_port_track
  import arbmon_pkg::*;
#(
  parameter int STARVE_LIMIT = 10,
  parameter int CNT_W        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic gnt,
  input  logic ack,
  input  logic any_hold,
  output logic hold,
  output logic proto_err,
  output logic waste_err,
  output logic starve_err
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STARVE_LIMIT);

  port_state_t      st_q, st_d;
  logic [CNT_W-1:0] wait_q;
  logic             gnt_q, ack_q;
  logic             waiting;
  logic             ack_stray, ack_long, gnt_long, gnt_busy, req_drop;

  assign hold    = (st_q == PS_HOLD);
  assign waiting = req && !gnt && !hold;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_IDLE: begin
        if (gnt)      st_d = PS_HOLD;
        else if (req) st_d = PS_WAIT;
      end
      PS_WAIT: begin
        if (gnt)       st_d = PS_HOLD;
        else if (!req) st_d = PS_IDLE;
      end
      PS_HOLD: begin
        if (ack) st_d = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  assign ack_stray  = ack && !hold;
  assign ack_long   = ack && ack_q;
  assign gnt_long   = gnt && gnt_q;
  assign gnt_busy   = gnt && any_hold;
  assign req_drop   = (st_q == PS_WAIT) && !req && !gnt;
  assign proto_err  = ack_stray || ack_long || gnt_long || gnt_busy || req_drop;
  assign waste_err  = gnt && !req;
  assign starve_err = waiting && (wait_q == LIMIT_V);

  always_ff @(posedge clk) begin
    gnt_q <= gnt;
    ack_q <= ack;
    if (rst) begin
      st_q   <= PS_IDLE;
      wait_q <= '0;
    end else begin
      st_q <= st_d;
      if (gnt)
        wait_q <= '0;
      else if (waiting && (wait_q <= LIMIT_V))
        wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/arbmon_grant_scan.sv
module arbmon_grant_scan #(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 2
) (
  input  logic [N_PORTS-1:0] gnt,
  output logic               multi,
  output logic [PORT_W-1:0]  first
);
  localparam int SUM_W = $clog2(N_PORTS + 1);

  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    first = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      total = total + SUM_W'(gnt[i]);
      if (gnt[i]) first = PORT_W'(i);
    end
  end

  assign multi = (total > SUM_W'(1));
endmodule

// File: rtl/arbmon_cause_sel.sv
module arbmon_cause_sel
  import arbmon_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 2
) (
  input  logic               mutex_hit,
  input  logic [PORT_W-1:0]  mutex_port,
  input  logic [N_PORTS-1:0] waste_vec,
  input  logic [N_PORTS-1:0] starve_vec,
  input  logic [N_PORTS-1:0] proto_vec,
  output cause_t             cause,
  output logic [PORT_W-1:0]  port
);
  function automatic logic [PORT_W-1:0] lowest(input logic [N_PORTS-1:0] v);
    logic [PORT_W-1:0] r;
    r = '0;
    for (int i = N_PORTS - 1; i >= 0; i--)
      if (v[i]) r = PORT_W'(i);
    return r;
  endfunction

  always_comb begin
    cause = CAUSE_NONE;
    port  = '0;
    if (mutex_hit) begin
      cause = CAUSE_MUTEX;
      port  = mutex_port;
    end else if (|waste_vec) begin
      cause = CAUSE_WASTE;
      port  = lowest(waste_vec);
    end else if (|starve_vec) begin
      cause = CAUSE_STARVE;
      port  = lowest(starve_vec);
    end else if (|proto_vec) begin
      cause = CAUSE_PROTO;
      port  = lowest(proto_vec);
    end
  end
endmodule

// File: rtl/arb_proto_monitor.sv
module arb_proto_monitor
  import arbmon_pkg::*;
#(
  parameter int N_PORTS      = 4,
  parameter int STARVE_LIMIT = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_PORTS-1:0]           req,
  input  logic [N_PORTS-1:0]           gnt,
  input  logic [N_PORTS-1:0]           ack,
  output logic [NUM_CLASSES-1:0]       err_sticky,
  output logic                         err_pulse,
  output logic [2:0]                   err_code,
  output logic [$clog2(N_PORTS)-1:0]   err_port
);
  localparam int PORT_W = $clog2(N_PORTS);
  localparam int CNT_W  = $clog2(STARVE_LIMIT + 2);

  logic [N_PORTS-1:0] hold_vec, proto_vec, waste_vec, starve_vec;
  logic               any_hold;
  logic               mutex_hit;
  logic [PORT_W-1:0]  mutex_port, sel_port;
  cause_t             sel_cause;

  assign any_hold = |hold_vec;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    arbmon_port_track #(
      .STARVE_LIMIT(STARVE_LIMIT),
      .CNT_W       (CNT_W)
    ) u_track (
      .clk       (clk),
      .rst       (rst),
      .req       (req[p]),
      .gnt       (gnt[p]),
      .ack       (ack[p]),
      .any_hold  (any_hold),
      .hold      (hold_vec[p]),
      .proto_err (proto_vec[p]),
      .waste_err (waste_vec[p]),
      .starve_err(starve_vec[p])
    );
  end

  arbmon_grant_scan #(
    .N_PORTS(N_PORTS),
    .PORT_W (PORT_W)
  ) u_scan (
    .gnt  (gnt),
    .multi(mutex_hit),
    .first(mutex_port)
  );

  arbmon_cause_sel #(
    .N_PORTS(N_PORTS),
    .PORT_W (PORT_W)
  ) u_sel (
    .mutex_hit (mutex_hit),
    .mutex_port(mutex_port),
    .waste_vec (waste_vec),
    .starve_vec(starve_vec),
    .proto_vec (proto_vec),
    .cause     (sel_cause),
    .port      (sel_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_sticky <= '0;
      err_pulse  <= 1'b0;
      err_code   <= 3'd0;
      err_port   <= '0;
    end else begin
      err_sticky <= err_sticky | {|proto_vec, |starve_vec, |waste_vec, mutex_hit};
      err_pulse  <= (sel_cause != CAUSE_NONE);
      err_code   <= sel_cause;
      err_port   <= sel_port;
    end
  end
endmodule

// File: rtl/arbmon_props.sv
module arbmon_props #(
  parameter int N_PORTS      = 4,
  parameter int STARVE_LIMIT = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N_PORTS-1:0]         req,
  input logic [N_PORTS-1:0]         gnt,
  input logic [N_PORTS-1:0]         ack,
  input logic [N_PORTS-1:0]         hold_vec,
  input logic [3:0]                 err_sticky,
  input logic                       err_pulse,
  input logic [2:0]                 err_code,
  input logic [$clog2(N_PORTS)-1:0] err_port
);
  logic [N_PORTS-1:0] waste_prev;
  always_ff @(posedge clk) waste_prev <= gnt & ~req;

  a_r1_mutex: assert property (@(posedge clk) disable iff (rst)
    ($countones(gnt) > 1) |=> (err_sticky[0] && err_pulse));

  a_r2_waste: assert property (@(posedge clk) disable iff (rst)
    (|(gnt & ~req)) |=> err_sticky[1]);

  a_r5_double: assert property (@(posedge clk) disable iff (rst)
    (|(ack & $past(ack)) || |(gnt & $past(gnt))) |=> err_sticky[3]);

  a_r6_stray_ack: assert property (@(posedge clk) disable iff (rst)
    (|(ack & ~hold_vec)) |=> err_sticky[3]);

  a_r7_busy_grant: assert property (@(posedge clk) disable iff (rst)
    (|gnt && |hold_vec) |=> err_sticky[3]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(err_sticky) & ~err_sticky) == 4'd0));

  a_r9_pulse_flag: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (|err_sticky && err_code != 3'd0));

  a_r9_waste_port: assert property (@(posedge clk) disable iff (rst)
    (err_code == 3'd2) |-> waste_prev[err_port]);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (err_sticky == 4'd0 && !err_pulse && err_code == 3'd0));

  // R3: wait window tracked by a counter rather than a long delay
  localparam int CW = $clog2(STARVE_LIMIT + 2);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_wait
    logic [CW-1:0] wcnt;
    always_ff @(posedge clk) begin
      if (rst) wcnt <= '0;
      else if (gnt[p]) wcnt <= '0;
      else if (req[p] && !hold_vec[p] && wcnt <= CW'(STARVE_LIMIT)) wcnt <= wcnt + 1'b1;
    end
    a_r3_starve: assert property (@(posedge clk) disable iff (rst)
      (req[p] && !gnt[p] && !hold_vec[p] && wcnt == CW'(STARVE_LIMIT)) |=> err_sticky[2]);
  end
endmodule

bind arb_proto_monitor arbmon_props #(
  .N_PORTS     (N_PORTS),
  .STARVE_LIMIT(STARVE_LIMIT)
) u_props (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .gnt       (gnt),
  .ack       (ack),
  .hold_vec  (hold_vec),
  .err_sticky(err_sticky),
  .err_pulse (err_pulse),
  .err_code  (err_code),
  .err_port  (err_port)
);

// File: tb/arb_proto_monitor_tb.sv
module arb_proto_monitor_tb;
  localparam int N   = 4;
  localparam int LIM = 10;
  localparam int PW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0, gnt = '0, ack = '0;
  logic [3:0]    err_sticky;
  logic          err_pulse;
  logic [2:0]    err_code;
  logic [PW-1:0] err_port;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  arb_proto_monitor #(.N_PORTS(N), .STARVE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .ack(ack),
    .err_sticky(err_sticky), .err_pulse(err_pulse),
    .err_code(err_code), .err_port(err_port)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 waiting, 2 holding
  int   m_st [N];
  int   m_cnt[N];
  bit   m_gq [N];
  bit   m_aq [N];
  logic [3:0] e_sticky;
  bit   e_pulse;
  int   e_code;
  int   e_port;

  function automatic int low_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic void model_cycle();
    bit any_own = 0;
    bit mutex;
    logic [N-1:0] wv = '0, sv = '0, pv = '0;
    for (int i = 0; i < N; i++) if (m_st[i] == 2) any_own = 1;
    mutex = ($countones(gnt) > 1);
    for (int i = 0; i < N; i++) begin
      wv[i] = gnt[i] && !req[i];
      sv[i] = req[i] && !gnt[i] && m_st[i] != 2 && m_cnt[i] == LIM;
      pv[i] = (ack[i] && m_st[i] != 2) || (ack[i] && m_aq[i]) ||
              (gnt[i] && m_gq[i]) || (gnt[i] && any_own) ||
              (m_st[i] == 1 && !req[i] && !gnt[i]);
    end
    if (mutex)    begin e_code = 1; e_port = low_idx(gnt); end
    else if (|wv) begin e_code = 2; e_port = low_idx(wv);  end
    else if (|sv) begin e_code = 3; e_port = low_idx(sv);  end
    else if (|pv) begin e_code = 4; e_port = low_idx(pv);  end
    else          begin e_code = 0; e_port = 0;            end
    e_pulse  = (e_code != 0);
    e_sticky = e_sticky | {|pv, |sv, |wv, mutex};
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) m_cnt[i] = 0;
      else if (req[i] && m_st[i] != 2 && m_cnt[i] <= LIM) m_cnt[i]++;
      case (m_st[i])
        0: if (gnt[i]) m_st[i] = 2; else if (req[i]) m_st[i] = 1;
        1: if (gnt[i]) m_st[i] = 2; else if (!req[i]) m_st[i] = 0;
        default: if (ack[i]) m_st[i] = 0;
      endcase
      m_gq[i] = gnt[i];
      m_aq[i] = ack[i];
    end
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (err_sticky !== e_sticky || err_pulse !== e_pulse ||
        int'(err_code) != e_code || int'(err_port) != e_port) begin
      n_fail++;
      $display("FAIL %s: sticky=%b pulse=%b code=%0d port=%0d expected sticky=%b pulse=%b code=%0d port=%0d",
               tag, err_sticky, err_pulse, err_code, err_port, e_sticky, e_pulse, e_code, e_port);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] g,
                      input logic [N-1:0] a, input string tag);
    req = r; gnt = g; ack = a;
    model_cycle();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; gnt = '0; ack = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_cnt[i] = 0; m_gq[i] = 0; m_aq[i] = 0;
    end
    e_sticky = '0; e_pulse = 0; e_code = 0; e_port = 0;
    compare("R10 reset state");
  endtask

  initial begin
    do_reset();
    // clean handshake on port 1
    step(4'b0010, 4'b0000, 4'b0000, "R9 clean request");
    step(4'b0010, 4'b0000, 4'b0000, "R9 clean request");
    step(4'b0010, 4'b0010, 4'b0000, "R9 clean grant");
    step(4'b0000, 4'b0000, 4'b0000, "R9 clean hold");
    step(4'b0000, 4'b0000, 4'b0010, "R9 clean ack");
    step(4'b0000, 4'b0000, 4'b0000, "R9 clean idle");

    do_reset();
    for (int k = 0; k < LIM + 3; k++)
      step(4'b0100, 4'b0000, 4'b0000, "R3 starvation window");
    step(4'b0100, 4'b0100, 4'b0000, "R3 late grant");
    step(4'b0000, 4'b0000, 4'b0100, "R3 release");
    for (int k = 0; k < LIM; k++)
      step(4'b0100, 4'b0000, 4'b0000, "R3 count cleared by grant");
    step(4'b0100, 4'b0100, 4'b0000, "R3 grant at limit");

    do_reset();
    step(4'b0011, 4'b0000, 4'b0000, "R1 two requests");
    step(4'b0011, 4'b0011, 4'b0000, "R1 double grant");
    for (int k = 0; k < 4; k++)
      step(4'b0000, 4'b0000, 4'b0000, "R8 sticky after mutex");

    do_reset();
    step(4'b0000, 4'b1000, 4'b0000, "R2 grant without request");

    do_reset();
    step(4'b0001, 4'b0000, 4'b0000, "R4 request");
    step(4'b0001, 4'b0000, 4'b0000, "R4 request");
    step(4'b0000, 4'b0000, 4'b0000, "R4 request dropped");

    do_reset();
    step(4'b0010, 4'b0000, 4'b0000, "R5 request");
    step(4'b0010, 4'b0010, 4'b0000, "R5 grant");
    step(4'b0010, 4'b0010, 4'b0000, "R5 grant second cycle");

    do_reset();
    step(4'b0001, 4'b0001, 4'b0000, "R5 grant");
    step(4'b0000, 4'b0000, 4'b0001, "R5 ack");
    step(4'b0000, 4'b0000, 4'b0001, "R5 ack second cycle");

    do_reset();
    step(4'b0000, 4'b0000, 4'b0100, "R6 ack while idle");

    do_reset();
    step(4'b0001, 4'b0001, 4'b0000, "R7 port0 owns");
    step(4'b0010, 4'b0000, 4'b0000, "R7 port1 requests");
    step(4'b0010, 4'b0010, 4'b0000, "R7 grant while busy");

    do_reset();
    step(4'b0010, 4'b0011, 4'b0000, "R9 mutex outranks waste");

    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] r, g, a;
      r = N'($urandom) & N'($urandom);
      g = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      a = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      step(r, g, a, "R8 R9 random traffic");
    end
    step('0, '0, '0, "R8 random end");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule